// File: doc/BRIEF.md
# Lockable Pin Multiplexing Matrix

This block connects a bank of peripheral signals to a bank of shared IO pads through two programmable crossbars. Each peripheral input has a select register that picks one pad input or a fixed level. Each pad has a select register that picks one peripheral output, a fixed level, or leaves the pad undriven. For each pad the block produces a data bit and an output-enable bit. The pad cell uses the enable to turn its driver on or off.

Every select register has its own lock bit. Software can clear a lock bit but can never set it again. Once a lock is cleared, the matching select keeps its value until the next reset. Boot code can therefore fix the pin assignment, and later software cannot change it.

All registers are reached through a plain write/read port. On this port, `reg_addr[AW-1:IDXW]` chooses one of four register groups and `reg_addr[IDXW-1:0]` chooses the entry within that group.

Top module: `pin_matrix`

## Requirements
- R1: An input select holding 0 drives its peripheral input with constant 0. An input select holding 1 drives it with constant 1.
- R2: An input select value v >= 2 connects pad v-2 to the peripheral input. If v-2 is not a valid pad index, the peripheral input is constant 0.
- R3: An output select of 0 gives pad data 0 with enable 1. A select of 1 gives data 1 with enable 1. A select of 2 gives enable 0 and data 0 (high-Z).
- R4: An output select value v >= 3 drives the pad from peripheral output v-3 with enable 1. If v-3 is not a valid peripheral index, the pad is high-Z (enable 0, data 0).
- R5: After reset, every input select reads 0, every output select reads 2, and every lock bit reads 1. As a result, all pads are high-Z and all peripheral inputs are 0.
- R6: A write to a lock bit looks only at `reg_wdata[0]`. Writing 0 clears the lock. Writing 1 has no effect, so a cleared lock stays cleared until reset.
- R7: While a select's lock bit is 0, writes to that select are ignored. Its value and the outputs it controls stay unchanged until reset.
- R8: The address groups are: 0 = input selects, 1 = input locks, 2 = output selects, 3 = output locks. A select keeps the low select-width bits of `reg_wdata`. A read returns the stored value zero-extended, with lock bits read in bit 0. Reads of entries past a group's count return 0, and writes to such entries change nothing.
- R9: A select write on one rising clock edge shows up on `periph_in`, `pad_out` and `pad_oe` right after that edge. The outputs are combinational from the stored selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Group (upper two bits) and entry index |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| pad_in | input | NPAD | Values received from the pads |
| periph_out | input | NOUT | Values driven by the peripherals |
| periph_in | output | NIN | Values delivered to the peripherals |
| pad_out | output | NPAD | Data driven to each pad |
| pad_oe | output | NPAD | Output enable for each pad; 0 means high-Z |

## Verification
The bench drives each fixed-level code (0 and 1 for inputs; 0, 1 and 2 for outputs) with the opposite level on every pad and peripheral line. This shows that the constant wins over the data path. Each valid routed code is tried with one-hot and inverted patterns, which exposes an off-by-one in the index offset. The highest, out-of-range code is driven with all-ones data, which separates "constant 0 / high-Z" from routing to a neighbouring line. After these directed cases, random select writes, lock clears and data changes are checked against a bench model. A final reset shows that cleared locks and frozen selects return to their reset values.

// File: rtl/pin_matrix.sv
`timescale 1ns/1ps
module pin_matrix #(
  parameter int NPAD = 5,
  parameter int NIN  = 3,
  parameter int NOUT = 4,
  parameter int DW   = 8,
  localparam int ISW  = $clog2(NPAD + 2),
  localparam int OSW  = $clog2(NOUT + 3),
  localparam int IDXW = $clog2((NIN > NPAD) ? NIN : NPAD),
  localparam int AW   = IDXW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPAD-1:0] pad_in,
  input  logic [NOUT-1:0] periph_out,
  output logic [NIN-1:0]  periph_in,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe
);

  localparam logic [1:0] GRP_ISEL  = 2'd0;
  localparam logic [1:0] GRP_ILOCK = 2'd1;
  localparam logic [1:0] GRP_OSEL  = 2'd2;
  localparam logic [1:0] GRP_OLOCK = 2'd3;

  logic [1:0]      grp;
  logic [IDXW-1:0] idx;
  assign grp = reg_addr[AW-1:IDXW];
  assign idx = reg_addr[IDXW-1:0];

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  logic [ISW-1:0] isel_q [NIN];
  logic [NIN-1:0] ilock_q;
  logic [OSW-1:0] osel_q [NPAD];
  logic [NPAD-1:0] olock_q;

  for (genvar k = 0; k < NIN; k++) begin : g_in
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        isel_q[k]  <= '0;
        ilock_q[k] <= 1'b1;
      end else if (reg_we && idx == IDXW'(k)) begin
        if (grp == GRP_ISEL && ilock_q[k]) isel_q[k] <= reg_wdata[ISW-1:0];
        if (grp == GRP_ILOCK && !reg_wdata[0]) ilock_q[k] <= 1'b0;
      end
    end

    always_comb begin
      periph_in[k] = (isel_q[k] == ISW'(1));
      for (int p = 0; p < NPAD; p++)
        if (isel_q[k] == ISW'(p + 2)) periph_in[k] = pad_in[p];
    end

    p_const_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (isel_q[k] == ISW'(1)) |-> periph_in[k]);
    p_const_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (isel_q[k] == '0) |-> !periph_in[k]);
    p_oor_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(isel_q[k]) >= NPAD + 2) |-> !periph_in[k]);
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ilock_q[k] |=> !ilock_q[k]);
    p_frozen_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ilock_q[k] |=> $stable(isel_q[k]));
  end

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        osel_q[p]  <= OSW'(2);
        olock_q[p] <= 1'b1;
      end else if (reg_we && idx == IDXW'(p)) begin
        if (grp == GRP_OSEL && olock_q[p]) osel_q[p] <= reg_wdata[OSW-1:0];
        if (grp == GRP_OLOCK && !reg_wdata[0]) olock_q[p] <= 1'b0;
      end
    end

    always_comb begin
      pad_out[p] = (osel_q[p] == OSW'(1));
      pad_oe[p]  = (osel_q[p] == OSW'(0)) || (osel_q[p] == OSW'(1));
      for (int j = 0; j < NOUT; j++)
        if (osel_q[p] == OSW'(j + 3)) begin
          pad_out[p] = periph_out[j];
          pad_oe[p]  = 1'b1;
        end
    end

    p_hiz_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[p] |-> !pad_out[p]);
    p_hiz_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (osel_q[p] == OSW'(2)) |-> !pad_oe[p]);
    p_oor_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(osel_q[p]) >= NOUT + 3) |-> !pad_oe[p]);
    p_frozen_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !olock_q[p] |=> $stable(osel_q[p]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NIN; k++)
      if (idx == IDXW'(k)) begin
        if (grp == GRP_ISEL)  reg_rdata = DW'(isel_q[k]);
        if (grp == GRP_ILOCK) reg_rdata = DW'(ilock_q[k]);
      end
    for (int p = 0; p < NPAD; p++)
      if (idx == IDXW'(p)) begin
        if (grp == GRP_OSEL)  reg_rdata = DW'(osel_q[p]);
        if (grp == GRP_OLOCK) reg_rdata = DW'(olock_q[p]);
      end
  end

endmodule

// File: tb/test_pin_matrix.sv
`timescale 1ns/1ps
module test_pin_matrix;
  localparam int NPAD = 5;
  localparam int NIN  = 3;
  localparam int NOUT = 4;
  localparam int DW   = 8;
  localparam int IDXW = 3;
  localparam int AW   = 5;
  localparam int ISMAX = 7;
  localparam int OSMAX = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic [NPAD-1:0] pad_in = '0;
  logic [NOUT-1:0] periph_out = '0;
  logic [NIN-1:0]  periph_in;
  logic [NPAD-1:0] pad_out;
  logic [NPAD-1:0] pad_oe;

  pin_matrix #(.NPAD(NPAD), .NIN(NIN), .NOUT(NOUT), .DW(DW)) i_pin_matrix (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .periph_out(periph_out), .periph_in(periph_in), .pad_out(pad_out),
    .pad_oe(pad_oe));

  int n_chk = 0;
  int n_bad = 0;
  int m_isel [NIN];
  int m_osel [NPAD];
  bit m_il [NIN];
  bit m_ol [NPAD];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NIN-1:0] exp_pin();
    logic [NIN-1:0] r;
    for (int k = 0; k < NIN; k++) begin
      if (m_isel[k] == 1) r[k] = 1'b1;
      else if (m_isel[k] >= 2 && m_isel[k] - 2 < NPAD) r[k] = pad_in[m_isel[k] - 2];
      else r[k] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [NPAD-1:0] exp_oe();
    logic [NPAD-1:0] r;
    for (int p = 0; p < NPAD; p++)
      r[p] = (m_osel[p] <= 1) || (m_osel[p] >= 3 && m_osel[p] - 3 < NOUT);
    return r;
  endfunction

  function automatic logic [NPAD-1:0] exp_pout();
    logic [NPAD-1:0] r;
    for (int p = 0; p < NPAD; p++) begin
      if (m_osel[p] == 1) r[p] = 1'b1;
      else if (m_osel[p] >= 3 && m_osel[p] - 3 < NOUT) r[p] = periph_out[m_osel[p] - 3];
      else r[p] = 1'b0;
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NIN; k++) begin m_isel[k] = 0; m_il[k] = 1'b1; end
    for (int p = 0; p < NPAD; p++) begin m_osel[p] = 2; m_ol[p] = 1'b1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(int grp, int idx, logic [DW-1:0] data);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = {grp[1:0], idx[IDXW-1:0]};
    reg_wdata = data;
    case (grp)
      0: if (idx < NIN && m_il[idx]) m_isel[idx] = int'(data) % (ISMAX + 1);
      1: if (idx < NIN && !data[0]) m_il[idx] = 1'b0;
      2: if (idx < NPAD && m_ol[idx]) m_osel[idx] = int'(data) % (OSMAX + 1);
      default: if (idx < NPAD && !data[0]) m_ol[idx] = 1'b0;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd_chk(string tag, int grp, int idx, int exp);
    reg_addr = {grp[1:0], idx[IDXW-1:0]};
    #1;
    chk(tag, 32'(reg_rdata), exp);
  endtask

  task automatic chk_out(string tag);
    #1;
    chk({tag, " periph_in"}, 32'(periph_in), 32'(exp_pin()));
    chk({tag, " pad_out"}, 32'(pad_out), 32'(exp_pout()));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(exp_oe()));
  endtask

  task automatic chk_all_regs(string tag);
    for (int k = 0; k < NIN; k++) begin
      rd_chk({tag, " isel"}, 0, k, m_isel[k]);
      rd_chk({tag, " ilock"}, 1, k, int'(m_il[k]));
    end
    for (int p = 0; p < NPAD; p++) begin
      rd_chk({tag, " osel"}, 2, p, m_osel[p]);
      rd_chk({tag, " olock"}, 3, p, int'(m_ol[p]));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R5: reset values, all pads high-Z, inputs low
    pad_in = '1; periph_out = '1;
    chk_all_regs("R5 reset");
    chk_out("R5 reset");
    chk("R5 pad_oe all zero", 32'(pad_oe), 0);

    // R1: constants win over pad data
    wr(0, 0, 8'd1);
    pad_in = '0;
    chk_out("R1 const1");
    chk("R1 periph_in0 high", 32'(periph_in[0]), 1);
    wr(0, 0, 8'd0);
    pad_in = '1;
    chk_out("R1 const0");

    // R2: each pad routed, one-hot and inverted patterns
    for (int p = 0; p < NPAD; p++) begin
      wr(0, 1, 8'(p + 2));
      pad_in = NPAD'(1 << p);
      chk_out("R2 onehot");
      pad_in = ~NPAD'(1 << p);
      chk_out("R2 inverted");
    end
    wr(0, 2, 8'd7);
    pad_in = '1;
    chk_out("R2 out of range");
    chk("R2 oor input is zero", 32'(periph_in[2]), 0);

    // R3: fixed levels and high-Z
    periph_out = '1;
    wr(2, 0, 8'd0);
    chk_out("R3 drive low");
    periph_out = '0;
    wr(2, 1, 8'd1);
    chk_out("R3 drive high");
    wr(2, 2, 8'd2);
    periph_out = '1;
    chk_out("R3 highz");

    // R4: each peripheral routed, then past the last
    for (int j = 0; j < NOUT; j++) begin
      wr(2, 3, 8'(j + 3));
      periph_out = NOUT'(1 << j);
      chk_out("R4 onehot");
      periph_out = ~NOUT'(1 << j);
      chk_out("R4 inverted");
    end
    wr(2, 4, 8'd7);
    periph_out = '1;
    chk_out("R4 out of range");
    chk("R4 oor pad high-Z", 32'(pad_oe[4]), 0);

    // R8: truncation, readback and out-of-range entry
    wr(0, 2, 8'hF9);
    rd_chk("R8 isel truncated", 0, 2, 1);
    wr(2, 1, 8'hFC);
    rd_chk("R8 osel truncated", 2, 1, 4);
    wr(0, 5, 8'd3);
    rd_chk("R8 unused entry reads 0", 0, 5, 0);
    chk_all_regs("R8 readback");

    // R9: output visible right after the write edge
    pad_in = 5'b00100;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {2'd0, 3'd0}; reg_wdata = 8'd4;
    m_isel[0] = 4;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    chk("R9 periph_in0 after edge", 32'(periph_in[0]), 1);

    // R6: lock bit write semantics
    wr(1, 0, 8'hFF);
    rd_chk("R6 write one keeps lock", 1, 0, 1);
    wr(1, 0, 8'hFE);
    rd_chk("R6 write zero clears", 1, 0, 0);
    wr(1, 0, 8'h01);
    rd_chk("R6 cannot set again", 1, 0, 0);

    // R7: locked selects ignore writes
    wr(0, 0, 8'd1);
    rd_chk("R7 locked isel unchanged", 0, 0, 4);
    chk_out("R7 locked input outputs");
    wr(3, 3, 8'd0);
    wr(2, 3, 8'd0);
    rd_chk("R7 locked osel unchanged", 2, 3, 6);
    periph_out = 4'b1000;
    chk_out("R7 locked pad routing");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r;
      int g;
      @(negedge clk);
      pad_in = NPAD'($urandom);
      periph_out = NOUT'($urandom);
      r = int'($urandom % 32);
      g = (r < 15) ? 0 : (r < 30) ? 2 : (r == 30) ? 1 : 3;
      wr(g, int'($urandom % 8), 8'($urandom));
      chk_out("R1 R2 R3 R4 R7 random");
      if (it % 50 == 0) chk_all_regs("R6 R8 random readback");
    end

    // R5 / R7: reset releases locks and selects
    do_reset();
    chk_all_regs("R5 R7 after second reset");
    chk_out("R5 after second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule